// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight raw interrupt lines into a register of pending requests. Each line passes through a two-stage synchroniser, and its synchronised value is then read in one of two ways. A line in edge mode latches a request when it goes from low to high. The request stays set until an acknowledge clears it. A line in level mode shows its current synchronised level directly as its pending bit.

A per-line trigger-mode register picks the mode of each line. A value of 1 selects level mode and 0 selects edge mode. The register is written one byte at a time. Each write is ANDed with a fixed mask set per instance, so lines outside the mask cannot leave edge mode. An acknowledge is a one-cycle pulse that carries a 3-bit line number. It clears that line's pending bit only when the line is in edge mode. Priority resolution and command decoding belong to the logic around this block.

Top module: `irq_req_latch`

## Requirements
- R1: A synchronous reset clears every pending bit, clears the trigger-mode register (all lines in edge mode), and clears the recorded last levels.
- R2: On an edge-mode line, a synchronised low-to-high transition sets that line's pending bit.
- R3: On an edge-mode line, the pending bit stays set when the input falls, and it is not set again while the input stays high after an acknowledge.
- R4: On a level-mode line, the pending bit equals the synchronised input level: 1 while high, 0 while low.
- R5: An acknowledge (`ack_valid`=1, line number on `ack_line`) clears the pending bit of that line when it is in edge mode, and leaves every other bit unchanged.
- R6: An acknowledge aimed at a level-mode line has no effect on `pending`.
- R7: A write (`mode_we`=1) stores `mode_wdata & MODE_MASK` into the trigger-mode register on that clock edge. `mode_rdata` returns the stored value, with bit i = 1 meaning line i is level-triggered. The default mask is 8'hF0.
- R8: When a new edge on a line arrives in the same cycle as an acknowledge of that line, the pending bit ends up set.
- R9: An input change reaches `pending` on the third rising clock edge after it is applied, and not before.
- R10: On an edge-mode line, the last level follows the input, so a fall followed by a new rise sets the pending bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 8 | Raw interrupt lines, asynchronous |
| ack_valid | input | 1 | One-cycle acknowledge pulse |
| ack_line | input | 3 | Line number being acknowledged |
| mode_we | input | 1 | Trigger-mode register write enable |
| mode_wdata | input | 8 | Trigger-mode write byte |
| mode_rdata | output | 8 | Current trigger-mode register |
| pending | output | 8 | Pending request bits |

## Verification
The assertions assume that `ack_line` is always a valid line number. They also assume reset is held for at least one full clock before it is released, so that every `$past` term sees reset values. The bench drives all inputs on falling edges and holds reset for two cycles. It sends acknowledges only after a line's synchronised level has settled, except in the one test that lines up a new edge with an acknowledge on purpose.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    localparam trig_e RESET_TRIG = TRIG_EDGE;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef logic [STAGES-1:0][WIDTH-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/trig_mode_reg.sv
module trig_mode_reg
    import irq_latch_pkg::*;
#(
    parameter int unsigned             WIDTH = 8,
    parameter logic [WIDTH-1:0]        MASK  = 8'hF0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mode
);

    typedef struct packed {
        logic [WIDTH-1:0] trig;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.trig = wdata & MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.trig <= {WIDTH{RESET_TRIG}};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.trig;

    AST_MODE_WRITE_MASKED: assert property (@(posedge clk) disable iff (rst)
        we |=> (mode == ($past(wdata) & MASK))); // R7

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mode)); // R7

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned ID_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl_in,
    input  logic [WIDTH-1:0] mode,
    input  logic             ack_valid,
    input  logic [ID_W-1:0]  ack_line,
    output logic [WIDTH-1:0] pending
);

    typedef struct packed {
        logic [WIDTH-1:0] pend;
        logic [WIDTH-1:0] last;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [WIDTH-1:0] ack_vec;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] edge_next;

    always_comb begin
        ack_vec   = ack_valid ? (WIDTH'(1) << ack_line) : '0;
        rise      = lvl_in & ~st_q.last;
        // new edge overrides a same-cycle acknowledge
        edge_next = (st_q.pend & ~ack_vec) | rise;
        st_d.pend = (mode & lvl_in) | (~mode & edge_next);
        st_d.last = lvl_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pend;

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pending & $past(mode)) == ($past(lvl_in) & $past(mode)))); // R4

    AST_EDGE_SET: assert property (@(posedge clk) disable iff (rst)
        (|(lvl_in & ~st_q.last & ~mode)) |=>
        ((pending & $past(lvl_in & ~st_q.last & ~mode)) == $past(lvl_in & ~st_q.last & ~mode))); // R8

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pending & $past(pending & ~mode & ~ack_vec)) ==
                  $past(pending & ~mode & ~ack_vec))); // R3

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !mode[ack_line] && !(lvl_in[ack_line] && !st_q.last[ack_line]))
        |=> !pending[$past(ack_line)]); // R5

    AST_LAST_TRACK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st_q.last == $past(lvl_in))); // R10

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int unsigned           NUM_LINES   = 8,
    parameter int unsigned           SYNC_STAGES = 2,
    parameter logic [NUM_LINES-1:0]  MODE_MASK   = 8'hF0,
    localparam int unsigned          ID_W        = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 ack_valid,
    input  logic [ID_W-1:0]      ack_line,
    input  logic                 mode_we,
    input  logic [NUM_LINES-1:0] mode_wdata,
    output logic [NUM_LINES-1:0] mode_rdata,
    output logic [NUM_LINES-1:0] pending
);

    logic [NUM_LINES-1:0] irq_sync_lvl;
    logic [NUM_LINES-1:0] trig_mode;

    irq_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (irq_in),
        .sync_out (irq_sync_lvl)
    );

    trig_mode_reg #(
        .WIDTH (NUM_LINES),
        .MASK  (MODE_MASK)
    ) u_mode (
        .clk   (clk),
        .rst   (rst),
        .we    (mode_we),
        .wdata (mode_wdata),
        .mode  (trig_mode)
    );

    irq_pend_bank #(
        .WIDTH (NUM_LINES),
        .ID_W  (ID_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .lvl_in    (irq_sync_lvl),
        .mode      (trig_mode),
        .ack_valid (ack_valid),
        .ack_line  (ack_line),
        .pending   (pending)
    );

    assign mode_rdata = trig_mode;

    AST_MODE_IN_MASK: assert property (@(posedge clk) disable iff (rst)
        mode_we |=> ((mode_rdata & ~MODE_MASK) == '0)); // R7

    AST_LEVEL_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && trig_mode[ack_line] && $stable(irq_sync_lvl[ack_line]))
        |=> (pending[$past(ack_line)] == $past(irq_sync_lvl[ack_line]))); // R6

endmodule

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_line = '0;
    logic       mode_we = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic [7:0] mode_rdata;
    logic [7:0] pending;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    irq_req_latch u_dut (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .ack_valid  (ack_valid),
        .ack_line   (ack_line),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .mode_rdata (mode_rdata),
        .pending    (pending)
    );

    // {irq[7:0], ack_v, ack_line[2:0], expected pending[7:0]}, mode = 8'hF0
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {8'h01, 1'b0, 3'd0, 8'h01},
        {8'h00, 1'b0, 3'd0, 8'h01},
        {8'h00, 1'b1, 3'd0, 8'h00},
        {8'h11, 1'b0, 3'd0, 8'h11},
        {8'h11, 1'b1, 3'd4, 8'h11},
        {8'h10, 1'b1, 3'd0, 8'h10},
        {8'h00, 1'b0, 3'd0, 8'h00},
        {8'hF3, 1'b0, 3'd0, 8'hF3},
        {8'hF3, 1'b1, 3'd1, 8'hF1},
        {8'hF3, 1'b1, 3'd1, 8'hF1},
        {8'h03, 1'b1, 3'd0, 8'h00},
        {8'h02, 1'b0, 3'd0, 8'h00},
        {8'h0F, 1'b0, 3'd0, 8'h0D},
        {8'h0F, 1'b1, 3'd2, 8'h09}
    };

    function automatic string vec_tag(int i);
        case (i)
            0:       return "R2";
            1, 9:    return "R3";
            2, 5:    return "R5";
            3, 6, 7: return "R4";
            4:       return "R6";
            8, 13:   return "R5";
            10, 11:  return "R3";
            default: return "R10";
        endcase
    endfunction

    task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_mode(logic [7:0] d);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = d;
        @(posedge clk);
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic pulse_ack(logic [2:0] ln);
        @(negedge clk);
        ack_valid = 1'b1; ack_line = ln;
        @(posedge clk);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic run_vec(logic [19:0] v, string tag);
        @(negedge clk);
        irq_in = v[19:12];
        repeat (3) @(posedge clk);
        @(negedge clk);
        ack_valid = v[11]; ack_line = v[10:8];
        @(posedge clk);
        @(negedge clk);
        ack_valid = 1'b0;
        check(pending, v[7:0], tag);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(pending, 8'h00, "R1");
        check(mode_rdata, 8'h00, "R1");

        // R7: masked writes
        write_mode(8'hFF);
        check(mode_rdata, 8'hF0, "R7");
        write_mode(8'h5A);
        check(mode_rdata, 8'h50, "R7");
        write_mode(8'hF0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i], vec_tag(i));
        end

        // R8: new edge on line 3 coincides with its acknowledge
        @(negedge clk); irq_in = 8'h07;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(pending, 8'h09, "R3");
        irq_in = 8'h0F;
        repeat (2) @(posedge clk);
        @(negedge clk);
        ack_valid = 1'b1; ack_line = 3'd3;
        @(posedge clk);
        @(negedge clk);
        ack_valid = 1'b0;
        check(pending, 8'h09, "R8");

        // R9: three-edge latency
        pulse_ack(3'd0);
        irq_in = 8'h0E;
        repeat (4) @(posedge clk);
        @(negedge clk);
        irq_in = 8'h0F;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(pending, 8'h08, "R9");
        @(posedge clk);
        @(negedge clk);
        check(pending, 8'h09, "R9");

        // R1: mid-run reset returns every line to edge mode
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(pending, 8'h00, "R1");
        check(mode_rdata, 8'h00, "R1");
        irq_in = 8'h1F;
        repeat (3) @(posedge clk);
        pulse_ack(3'd4);
        check(pending, 8'h0F, "R1");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule